// File: doc/BRIEF.md
# Reloading Timer Bank

A memory-mapped timer peripheral holding three down-counting channels and one free-running 40-bit timestamp counter. Two channels are 16 bits wide and one is 32 bits wide. Each channel counts on one of two tick-enable inputs: a fast one or a slow one, chosen per channel. When a channel steps below zero it latches an interrupt flag, and that flag drives the channel's own interrupt line. Software drops the flag by writing any value to the channel's clear register. In periodic mode the channel then restarts from its load register. Otherwise it wraps to all ones and keeps running.

The timestamp counter counts up on a third tick input while its enable bit is set. It never interrupts. Software reads it as a low word and a high word, and the enable bit lives in the high-word register. The bus is word-wide. Writes take effect on the next clock edge, and read data is combinational from the address.

Top module: `timer_bank`

## Requirements
- R1: Channel A uses word offsets 0x00/0x04/0x08/0x0C for load/value/control/clear. Channel B uses 0x20..0x2C and channel C uses 0x80..0x8C in the same order. A and B keep 16 bits and C keeps 32; upper write bits are dropped. The load register reads back its stored value.
- R2: A write to a load register also places that value in the channel's counter. The value register is read-only and returns the live count.
- R3: Control bit 7 enables counting, bit 6 selects periodic mode and bit 3 selects the fast tick; the control register reads back these three bits. An enabled channel steps once per pulse of its selected tick only. A disabled channel holds its count.
- R4: In periodic mode, a tick at count zero reloads from the load register and sets the interrupt. A load value N gives an interrupt every N+1 ticks.
- R5: With periodic mode off, a tick at count zero wraps the counter to all ones (0xFFFF for A/B) and sets the interrupt.
- R6: A write of any data to a clear register clears that channel's interrupt, and the interrupt otherwise stays set. If an underflow occurs in the same cycle, the interrupt stays set. irq bit 0/1/2 belongs to A/B/C.
- R7: If a load write coincides with a counting tick, the counter takes the written value.
- R8: The 40-bit timestamp counter increments by one per stamp_tick pulse while enabled. Offset 0x60 reads its low 32 bits.
- R9: Offset 0x64 reads the counter's bits 39:32 in bits 7:0 and the enable in bit 8. Writing 0x64 sets the enable from data bit 8.
- R10: After reset every register, count and interrupt is zero. Unmapped offsets (including misaligned addresses and the read-only 0x60) read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, captured on the clock edge |
| bus_addr | input | 8 | Byte offset of the accessed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| fast_tick | input | 1 | Single-cycle enable for the fast count rate |
| slow_tick | input | 1 | Single-cycle enable for the slow count rate |
| stamp_tick | input | 1 | Single-cycle enable for the timestamp counter |
| irq | output | 3 | Per-channel interrupt, bit 0 = A, bit 1 = B, bit 2 = C |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a clear write and an underflow on the same channel. The bench loads channel A with zero and then, in one cycle, raises fast_tick while writing the clear register. It then checks that irq stays high, and that a later clear without a tick drops it. The second pair is a load write and a counting tick. The bench drives both in one cycle and expects the value register to show the written value and not the value minus one.

// File: rtl/timer_bank_pkg.sv
package timer_bank_pkg;
  localparam int BUS_W    = 32;
  localparam int ADDR_W   = 8;
  localparam int NUM_CH   = 3;
  localparam int NARROW_W = 16;
  localparam int WIDE_W   = 32;
  localparam int STAMP_W  = 40;
  localparam int STAMP_HI = STAMP_W - BUS_W;

  // control bit positions
  localparam int CB_EN   = 7;
  localparam int CB_PER  = 6;
  localparam int CB_FAST = 3;

  // register slot within a channel, taken from addr[3:2]
  typedef enum logic [1:0] {
    SLOT_LOAD  = 2'd0,
    SLOT_VALUE = 2'd1,
    SLOT_CTRL  = 2'd2,
    SLOT_CLEAR = 2'd3
  } slot_e;

  localparam logic [ADDR_W-1:0] STAMP_LO_OFS = 8'h60;
  localparam logic [ADDR_W-1:0] STAMP_HI_OFS = 8'h64;
  localparam int STAMP_EN_BIT = 8;

  function automatic logic [ADDR_W-1:0] chan_base(input int idx);
    case (idx)
      0:       return 8'h00;
      1:       return 8'h20;
      default: return 8'h80;
    endcase
  endfunction

  function automatic int chan_width(input int idx);
    return (idx == NUM_CH - 1) ? WIDE_W : NARROW_W;
  endfunction

  function automatic logic [BUS_W-1:0] pack_ctrl(input logic en,
                                                  input logic per,
                                                  input logic fast);
    logic [BUS_W-1:0] v;
    v = '0;
    v[CB_EN]   = en;
    v[CB_PER]  = per;
    v[CB_FAST] = fast;
    return v;
  endfunction

  function automatic logic [BUS_W-1:0] pack_stamp_hi(input logic [STAMP_HI-1:0] hi,
                                                      input logic en);
    logic [BUS_W-1:0] v;
    v = '0;
    v[STAMP_HI-1:0]  = hi;
    v[STAMP_EN_BIT]  = en;
    return v;
  endfunction
endpackage

// File: rtl/timer_chan.sv
module timer_chan
  import timer_bank_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_load,
  input  logic         wr_ctrl,
  input  logic         wr_clear,
  input  logic [W-1:0] load_data,
  input  logic [2:0]   ctrl_data,   // {en, per, fast}
  input  logic         fast_tick,
  input  logic         slow_tick,
  output logic [W-1:0] load_q,
  output logic [W-1:0] cnt_q,
  output logic         en_q,
  output logic         per_q,
  output logic         fast_q,
  output logic         irq_q,
  output logic         adv,
  output logic         uflow
);
  function automatic logic [W-1:0] step_down(input logic [W-1:0] cur,
                                              input logic [W-1:0] rel,
                                              input logic periodic);
    if (cur == '0) return periodic ? rel : '1;
    return cur - 1'b1;
  endfunction

  assign adv   = en_q & (fast_q ? fast_tick : slow_tick);
  assign uflow = adv & (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      load_q <= '0;
      cnt_q  <= '0;
    end else if (wr_load) begin
      load_q <= load_data;
      cnt_q  <= load_data;
    end else if (adv) begin
      cnt_q  <= step_down(cnt_q, load_q, per_q);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      per_q  <= 1'b0;
      fast_q <= 1'b0;
    end else if (wr_ctrl) begin
      en_q   <= ctrl_data[2];
      per_q  <= ctrl_data[1];
      fast_q <= ctrl_data[0];
    end
  end

  // underflow has priority over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n)        irq_q <= 1'b0;
    else if (uflow)    irq_q <= 1'b1;
    else if (wr_clear) irq_q <= 1'b0;
  end
endmodule

// File: rtl/timer_stamp.sv
module timer_stamp
  import timer_bank_pkg::*;
#(
  parameter int W = STAMP_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic         en_data,
  input  logic         tick,
  output logic [W-1:0] cnt_q,
  output logic         en_q,
  output logic         adv
);
  assign adv = en_q & tick;

  always_ff @(posedge clk) begin
    if (!rst_n)     en_q <= 1'b0;
    else if (wr_en) en_q <= en_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt_q <= '0;
    else if (adv) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/timer_bank.sv
module timer_bank
  import timer_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              fast_tick,
  input  logic              slow_tick,
  input  logic              stamp_tick,
  output logic [NUM_CH-1:0] irq
);
  // named internal events, observed by the bound checker
  logic [NUM_CH-1:0]            ch_adv, ch_uflow, ch_clr, ch_wrl, ch_hit;
  logic [NUM_CH-1:0][BUS_W-1:0] ch_cnt, ch_rd;
  logic [STAMP_W-1:0]           stamp_cnt;
  logic                         stamp_en, stamp_adv;
  logic                         mapped;

  logic        aligned;
  logic [1:0]  slot;
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign slot    = bus_addr[3:2];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam int CW = chan_width(i);
    localparam logic [ADDR_W-1:0] BASE = chan_base(i);

    logic [CW-1:0] load_q, cnt_q;
    logic en_q, per_q, fast_q;

    assign ch_hit[i] = aligned && (bus_addr[7:4] == BASE[7:4]);
    assign ch_wrl[i] = bus_wr && ch_hit[i] && (slot == SLOT_LOAD);
    assign ch_clr[i] = bus_wr && ch_hit[i] && (slot == SLOT_CLEAR);

    timer_chan #(.W(CW)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_load   (ch_wrl[i]),
      .wr_ctrl   (bus_wr && ch_hit[i] && (slot == SLOT_CTRL)),
      .wr_clear  (ch_clr[i]),
      .load_data (bus_wdata[CW-1:0]),
      .ctrl_data ({bus_wdata[CB_EN], bus_wdata[CB_PER], bus_wdata[CB_FAST]}),
      .fast_tick (fast_tick),
      .slow_tick (slow_tick),
      .load_q    (load_q),
      .cnt_q     (cnt_q),
      .en_q      (en_q),
      .per_q     (per_q),
      .fast_q    (fast_q),
      .irq_q     (irq[i]),
      .adv       (ch_adv[i]),
      .uflow     (ch_uflow[i])
    );

    assign ch_cnt[i] = BUS_W'(cnt_q);

    always_comb begin
      case (slot_e'(slot))
        SLOT_LOAD:  ch_rd[i] = BUS_W'(load_q);
        SLOT_VALUE: ch_rd[i] = BUS_W'(cnt_q);
        SLOT_CTRL:  ch_rd[i] = pack_ctrl(en_q, per_q, fast_q);
        default:    ch_rd[i] = '0;
      endcase
    end
  end

  timer_stamp #(.W(STAMP_W)) u_stamp (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (bus_wr && (bus_addr == STAMP_HI_OFS)),
    .en_data (bus_wdata[STAMP_EN_BIT]),
    .tick    (stamp_tick),
    .cnt_q   (stamp_cnt),
    .en_q    (stamp_en),
    .adv     (stamp_adv)
  );

  always_comb begin
    bus_rdata = '0;
    mapped    = 1'b0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (ch_hit[i]) begin
        bus_rdata = ch_rd[i];
        mapped    = 1'b1;
      end
    end
    if (bus_addr == STAMP_LO_OFS) begin
      bus_rdata = stamp_cnt[BUS_W-1:0];
      mapped    = 1'b1;
    end else if (bus_addr == STAMP_HI_OFS) begin
      bus_rdata = pack_stamp_hi(stamp_cnt[STAMP_W-1:BUS_W], stamp_en);
      mapped    = 1'b1;
    end
  end
endmodule

// File: rtl/timer_bank_chk.sv
module timer_bank_chk
  import timer_bank_pkg::*;
(
  input logic                         clk,
  input logic                         rst_n,
  input logic [NUM_CH-1:0]            irq,
  input logic [NUM_CH-1:0]            ch_adv,
  input logic [NUM_CH-1:0]            ch_uflow,
  input logic [NUM_CH-1:0]            ch_clr,
  input logic [NUM_CH-1:0]            ch_wrl,
  input logic [NUM_CH-1:0][BUS_W-1:0] ch_cnt,
  input logic [STAMP_W-1:0]           stamp_cnt,
  input logic                         stamp_adv,
  input logic                         mapped,
  input logic [BUS_W-1:0]             bus_rdata
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    // R4 / R5: an underflow raises the interrupt on the next edge
    p_uflow_sets_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ch_uflow[i] |=> irq[i]);
    // R6: a clear without a competing underflow drops the interrupt
    p_clear_drops_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_clr[i] && !ch_uflow[i]) |=> !irq[i]);
    // R6: the interrupt only rises after an underflow
    p_irq_rise_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq[i]) |-> $past(ch_uflow[i]));
    // R3: a channel with no tick and no load holds its count
    p_hold_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!ch_adv[i] && !ch_wrl[i]) |=> $stable(ch_cnt[i]));
  end

  // R8: the timestamp steps by exactly one per enabled tick
  p_stamp_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stamp_adv |=> (stamp_cnt == $past(stamp_cnt) + 1'b1));
  p_stamp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !stamp_adv |=> $stable(stamp_cnt));

  // R10: unmapped offsets read zero
  always_comb begin
    if (rst_n && !mapped) begin
      p_unmapped_zero_r10: assert (bus_rdata == '0);
    end
  end
endmodule

bind timer_bank timer_bank_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq       (irq),
  .ch_adv    (ch_adv),
  .ch_uflow  (ch_uflow),
  .ch_clr    (ch_clr),
  .ch_wrl    (ch_wrl),
  .ch_cnt    (ch_cnt),
  .stamp_cnt (stamp_cnt),
  .stamp_adv (stamp_adv),
  .mapped    (mapped),
  .bus_rdata (bus_rdata)
);

// File: tb/timer_bank_tb.sv
module timer_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        fast_tick = 1'b0, slow_tick = 1'b0, stamp_tick = 1'b0;
  logic [2:0]  irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  timer_bank u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fast_tick(fast_tick),
    .slow_tick(slow_tick), .stamp_tick(stamp_tick), .irq(irq)
  );

  localparam logic [2:0] OW = 3'd0;  // write a,d
  localparam logic [2:0] OR = 3'd1;  // read a, expect d
  localparam logic [2:0] OI = 3'd2;  // expect irq == d
  localparam logic [2:0] OF = 3'd3;  // fast tick
  localparam logic [2:0] OS = 3'd4;  // slow tick
  localparam logic [2:0] OT = 3'd5;  // stamp tick

  typedef struct packed {
    logic [2:0]  op;
    logic [7:0]  a;
    logic [31:0] d;
  } vec_t;

  localparam int NV = 61;
  localparam vec_t VEC [NV] = '{
    // channel A: setup order enable-off, load, enable (R1 R2 R3)
    '{OW, 8'h08, 32'h48}, '{OW, 8'h00, 32'h3}, '{OR, 8'h04, 32'h3},
    '{OR, 8'h00, 32'h3}, '{OR, 8'h08, 32'h48}, '{OF, 8'h00, 32'h0},
    '{OR, 8'h04, 32'h3}, '{OW, 8'h08, 32'hC8}, '{OR, 8'h08, 32'hC8},
    '{OF, 8'h00, 32'h0}, '{OF, 8'h00, 32'h0}, '{OF, 8'h00, 32'h0},
    '{OR, 8'h04, 32'h0}, '{OI, 8'h00, 32'h0},
    // R4: fourth tick reloads and interrupts
    '{OF, 8'h00, 32'h0}, '{OR, 8'h04, 32'h3}, '{OI, 8'h00, 32'h1},
    // R3: slow tick ignored when fast selected
    '{OS, 8'h00, 32'h0}, '{OR, 8'h04, 32'h3},
    // R6: any data clears
    '{OW, 8'h0C, 32'hDEADBEEF}, '{OI, 8'h00, 32'h0},
    // channel B free running on slow tick (R5)
    '{OW, 8'h28, 32'h80}, '{OW, 8'h20, 32'h1}, '{OS, 8'h00, 32'h0},
    '{OR, 8'h24, 32'h0}, '{OS, 8'h00, 32'h0}, '{OR, 8'h24, 32'hFFFF},
    '{OI, 8'h00, 32'h2}, '{OF, 8'h00, 32'h0}, '{OR, 8'h24, 32'hFFFF},
    '{OW, 8'h2C, 32'h0}, '{OI, 8'h00, 32'h0},
    // channel C periodic fast (R4 R1)
    '{OW, 8'h80, 32'h1}, '{OW, 8'h88, 32'hC8}, '{OR, 8'h84, 32'h1},
    '{OF, 8'h00, 32'h0}, '{OF, 8'h00, 32'h0}, '{OR, 8'h84, 32'h1},
    '{OI, 8'h00, 32'h4}, '{OW, 8'h8C, 32'h5}, '{OI, 8'h00, 32'h0},
    '{OW, 8'h80, 32'hFFFFFFFF}, '{OR, 8'h84, 32'hFFFFFFFF},
    // R1: 16-bit channel drops upper bits
    '{OW, 8'h00, 32'h12345678}, '{OR, 8'h04, 32'h5678},
    // timestamp (R8 R9)
    '{OT, 8'h00, 32'h0}, '{OR, 8'h60, 32'h0}, '{OW, 8'h64, 32'h100},
    '{OR, 8'h64, 32'h100}, '{OT, 8'h00, 32'h0}, '{OT, 8'h00, 32'h0},
    '{OT, 8'h00, 32'h0}, '{OR, 8'h60, 32'h3}, '{OW, 8'h64, 32'h0},
    '{OT, 8'h00, 32'h0}, '{OR, 8'h60, 32'h3}, '{OR, 8'h64, 32'h0},
    // R10: unmapped and read-only offsets
    '{OW, 8'h40, 32'hFFFFFFFF}, '{OR, 8'h40, 32'h0},
    '{OW, 8'h60, 32'hAAAA}, '{OR, 8'h60, 32'h3}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    bus_wr = 1'b0; fast_tick = 1'b0; slow_tick = 1'b0; stamp_tick = 1'b0;
  endtask

  task automatic rd_check(input logic [7:0] a, input logic [31:0] exp,
                          input string req);
    @(negedge clk);
    idle_inputs();
    bus_addr = a;
    #1;
    check(bus_rdata == exp, req, bus_rdata, exp);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    idle_inputs();
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R10: reset state
    rd_check(8'h00, 32'h0, "R10 reset load");
    rd_check(8'h04, 32'h0, "R10 reset value");
    rd_check(8'h88, 32'h0, "R10 reset ctrl");
    rd_check(8'h64, 32'h0, "R10 reset stamp hi");
    check(irq == 3'b000, "R10 reset irq", 32'(irq), 32'h0);

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      idle_inputs();
      case (VEC[k].op)
        OW: begin bus_wr = 1'b1; bus_addr = VEC[k].a; bus_wdata = VEC[k].d; end
        OR: begin
          bus_addr = VEC[k].a;
          #1;
          check(bus_rdata == VEC[k].d, $sformatf("R1-R10 vector %0d", k),
                bus_rdata, VEC[k].d);
        end
        OI: begin
          #1;
          check(irq == VEC[k].d[2:0], $sformatf("R6 irq vector %0d", k),
                32'(irq), VEC[k].d);
        end
        OF: fast_tick = 1'b1;
        OS: slow_tick = 1'b1;
        default: stamp_tick = 1'b1;
      endcase
    end

    // R6: clear coinciding with underflow leaves interrupt set
    wr(8'h00, 32'h0);
    @(negedge clk);
    idle_inputs();
    bus_wr = 1'b1; bus_addr = 8'h0C; bus_wdata = 32'h1; fast_tick = 1'b1;
    @(negedge clk);
    idle_inputs();
    #1;
    check(irq[0] == 1'b1, "R6 underflow beats clear", 32'(irq), 32'h1);
    wr(8'h0C, 32'h0);
    @(negedge clk);
    idle_inputs();
    #1;
    check(irq[0] == 1'b0, "R6 clear alone", 32'(irq), 32'h0);

    // R7: load write coinciding with a tick
    @(negedge clk);
    idle_inputs();
    bus_wr = 1'b1; bus_addr = 8'h00; bus_wdata = 32'h9; fast_tick = 1'b1;
    rd_check(8'h04, 32'h9, "R7 load wins over tick");
    @(negedge clk);
    idle_inputs();
    fast_tick = 1'b1;
    rd_check(8'h04, 32'h8, "R7 counting resumes");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule